// File: doc/BRIEF.md
# Processor Low-Power Mode Controller

This controller decides which low-power state a processor enters when it asks to sleep. It also drives the clock-stop enables for three clock groups: the core, the timer and serial peripherals, and the DMA engine. The choice depends on two standby-control bits, which software keeps in two separate control registers. The first bit selects standby. The second bit selects deep sleep. If neither bit is set, a sleep request gives plain sleep. A pending interrupt or a reset brings the controller back to running and turns every clock group back on.

The state is held in a register, so the response to a request or a wakeup appears one clock edge later. The clock enables are decoded from the state, so they change on that same edge. Reset is asynchronous and active low.

Top module: `lpm_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the state output is running (code 0) and all three clock enables are 1. This holds whatever state the controller was in before reset.
- R2: In running, with no interrupt pending, a sleep request enters standby (code 3) at the next edge when the first standby-control bit is 1. This happens whatever the value of the second bit.
- R3: In running, with no interrupt pending, a sleep request enters deep sleep (code 2) at the next edge when the first bit is 0 and the second bit is 1.
- R4: In running, with no interrupt pending, a sleep request enters plain sleep (code 1) at the next edge when both standby-control bits are 0.
- R5: Plain sleep clears only the core clock enable. Deep sleep clears the core and DMA enables and keeps the timer/serial enable at 1. Standby clears all three enables.
- R6: In any low-power state, a pending interrupt returns the state to running at the next edge, and all three enables return to 1.
- R7: A sleep request in running while an interrupt is pending is refused, and the state stays running.
- R8: In a low-power state with no interrupt pending, the state is held. Sleep requests and changes to either standby-control bit have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Request to enter a low-power state |
| stby_sel | input | 1 | Standby-control bit of the first register (selects standby) |
| deep_sel | input | 1 | Standby-control bit of the second register (selects deep sleep) |
| irq_pend | input | 1 | An interrupt is pending |
| pm_state | output | 2 | 0 running, 1 sleep, 2 deep sleep, 3 standby |
| core_clk_en | output | 1 | Core clock enable |
| tmr_ser_clk_en | output | 1 | Timer and serial clock enable |
| dma_clk_en | output | 1 | DMA clock enable |

## Verification
The block has no parameters, so the bench builds it exactly as it is. This makes the whole input space small. Four starting states combined with sixteen settings of the request, interrupt and two select bits give every transition, and the bench sweeps all of them. That covers select priority, refused requests, held states and wakeup. It also covers reset taken from each low-power state.

// File: rtl/lpm_ctrl.sv
module lpm_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       stby_sel,
  input  logic       deep_sel,
  input  logic       irq_pend,
  output logic [1:0] pm_state,
  output logic       core_clk_en,
  output logic       tmr_ser_clk_en,
  output logic       dma_clk_en
);
  localparam logic [1:0] ST_RUN  = 2'd0;
  localparam logic [1:0] ST_SLP  = 2'd1;
  localparam logic [1:0] ST_DEEP = 2'd2;
  localparam logic [1:0] ST_STBY = 2'd3;

  logic [1:0] st_q, st_d, pick;

  assign pick = stby_sel ? ST_STBY : (deep_sel ? ST_DEEP : ST_SLP);

  always_comb begin
    st_d = st_q;
    if (st_q == ST_RUN) begin
      if (sleep_req && !irq_pend) st_d = pick;
    end else if (irq_pend) begin
      st_d = ST_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;

  assign pm_state       = st_q;
  assign core_clk_en    = (st_q == ST_RUN);
  assign tmr_ser_clk_en = (st_q != ST_STBY);
  assign dma_clk_en     = (st_q == ST_RUN) || (st_q == ST_SLP);
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_req,
  input logic       stby_sel,
  input logic       deep_sel,
  input logic       irq_pend,
  input logic [1:0] pm_state,
  input logic       core_clk_en,
  input logic       tmr_ser_clk_en,
  input logic       dma_clk_en
);
  AST_STBY_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 2'd0 && sleep_req && !irq_pend && stby_sel) |=> (pm_state == 2'd3)); // R2
  AST_DEEP_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 2'd0 && sleep_req && !irq_pend && !stby_sel && deep_sel) |=> (pm_state == 2'd2)); // R3
  AST_SLEEP_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 2'd0 && sleep_req && !irq_pend && !stby_sel && !deep_sel) |=> (pm_state == 2'd1)); // R4
  AST_CORE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 2'd0 && sleep_req && !irq_pend) |=> !core_clk_en); // R5
  AST_WAKE_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state != 2'd0 && irq_pend) |=> (core_clk_en && tmr_ser_clk_en && dma_clk_en)); // R6
  AST_IRQ_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 2'd0 && irq_pend) |=> (pm_state == 2'd0)); // R7
  AST_LP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state != 2'd0 && !irq_pend) |=> $stable(pm_state)); // R8
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (.*);

// File: tb/sim_lpm_ctrl.sv
`timescale 1ns/1ps
module sim_lpm_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_req = 0, stby_sel = 0, deep_sel = 0, irq_pend = 0;
  logic [1:0] pm_state;
  logic core_clk_en, tmr_ser_clk_en, dma_clk_en;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  lpm_ctrl u0 (.clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .stby_sel(stby_sel),
    .deep_sel(deep_sel), .irq_pend(irq_pend), .pm_state(pm_state),
    .core_clk_en(core_clk_en), .tmr_ser_clk_en(tmr_ser_clk_en), .dma_clk_en(dma_clk_en));

  function automatic logic [1:0] model_next(logic [1:0] cur, logic s, logic i, logic a, logic b);
    if (cur == 2'd0) return (s && !i) ? (a ? 2'd3 : (b ? 2'd2 : 2'd1)) : 2'd0;
    return i ? 2'd0 : cur;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(string req, logic [1:0] st);
    check(req, pm_state, st);
    check(req, core_clk_en, st == 2'd0);
    check(req, tmr_ser_clk_en, st != 2'd3);
    check(req, dma_clk_en, st < 2'd2);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; sleep_req = 0; irq_pend = 0; stby_sel = 0; deep_sel = 0;
    #1 check_all("R1", 2'd0);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic enter(logic [1:0] tgt);
    if (tgt != 2'd0) begin
      sleep_req = 1; irq_pend = 0; stby_sel = (tgt == 2'd3); deep_sel = (tgt == 2'd2);
      @(negedge clk);
      sleep_req = 0; stby_sel = 0; deep_sel = 0;
    end
    check_all(tgt == 2'd3 ? "R2" : tgt == 2'd2 ? "R3" : tgt == 2'd1 ? "R4" : "R1", tgt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [1:0] exp;
    string tag;
    do_reset();
    check_all("R1", 2'd0);
    for (int t = 0; t < 4; t++) begin
      for (int v = 0; v < 16; v++) begin
        do_reset();
        enter(2'(t));
        sleep_req = v[0]; irq_pend = v[1]; stby_sel = v[2]; deep_sel = v[3];
        exp = model_next(2'(t), v[0], v[1], v[2], v[3]);
        if (t != 0) tag = v[1] ? "R6" : "R8";
        else if (v[1]) tag = "R7";
        else tag = "R5";
        @(negedge clk);
        check_all(tag, exp);
        sleep_req = 0; irq_pend = 0; stby_sel = 0; deep_sel = 0;
      end
    end
    for (int t = 1; t < 4; t++) begin
      do_reset();
      enter(2'(t));
      rst_n = 0;
      #1 check_all("R1", 2'd0);
      @(negedge clk); rst_n = 1;
      @(negedge clk); check_all("R1", 2'd0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule